// File: doc/BRIEF.md
# Stack-Top Cached Expression Unit

This block executes zero-address commands for a stack machine. The four topmost stack words are held in registers inside the block. Any deeper words live in a region of word-addressed data memory that starts at a fixed base address. The unit moves words between the registers and that region on its own whenever the register cache overflows or runs short. A command either loads a word from a memory address onto the stack, stores the top word to an address and removes it, or combines the two topmost words with add, subtract, multiply or divide. An arithmetic command names no operand: it always works on the second word from the top (left operand) and the top word (right operand), removes both, and pushes the result.

Commands enter through a valid/ready port. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for as long as the unit is busy with memory traffic. During that time the source must hold its command steady with `cmd_valid` high, and nothing is taken. One synchronous single-port memory interface carries the variable loads and stores and also the spill and fill traffic. A read returns its data on `mem_rdata` in the cycle after the request. Two sticky flags record an underflow and a division by zero. Both flags clear only on reset.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset `cmd_ready` is 1, `busy` is 0, `err_underflow` and `err_divzero` are 0, and `mem_req` is 0. The stack is empty and the spill pointer sits at `SPILL_BASE` (default 16'hFF00).
- R2: Command code 0 (push) reads the 32-bit word at `cmd_addr` and places it on top of the stack. With fewer than four words cached, `cmd_ready` stays low for exactly 2 cycles after acceptance.
- R3: Command code 1 (pop) writes the top word to `cmd_addr` and removes it from the stack. `cmd_ready` stays low for 1 cycle, or for 3 cycles if a refill follows (R9).
- R4: Codes 2 (add), 3 (subtract) and 4 (multiply) replace the two topmost words with (second op top). Subtract gives second minus top. Multiply keeps the low 32 bits. With no refill the result is in place when the command is accepted, and `cmd_ready` stays high.
- R5: Code 5 (divide) gives the signed quotient of second divided by top, truncated toward zero. The quotient of 32'h80000000 by -1 is 32'h80000000.
- R6: A divide whose top word is 0 pushes 0 in place of both operands and sets `err_divzero`. The flag stays set until reset.
- R7: A pop on an empty stack, or an arithmetic command with fewer than two words on the stack, sets `err_underflow` (sticky until reset). It leaves the stack unchanged and writes no memory.
- R8: A push made while four words are cached first writes the bottom cached word to address `SPILL_BASE + k`, where k is the number of words already spilled. The push then proceeds, and `cmd_ready` stays low for 3 cycles. Last-in first-out order is kept across the spill region.
- R9: When a pop or an arithmetic command leaves one word cached and the spill region holds words, the unit reads back the most recently spilled word and places it below the cached one. This adds 2 busy cycles. The spill pointer drops by one, so the next spill reuses that address.
- R10: While `cmd_ready` is low, a held command is not taken. It is taken on the first edge at which `cmd_ready` is high.
- R11: Codes 6 and 7 are accepted and ignored. They do not change the stack, the flags or memory, and they cause no busy cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div, 6-7 ignored) |
| cmd_addr | input | 16 | Word address for push and pop |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Unit is carrying out memory traffic for a command |
| err_underflow | output | 1 | Sticky underflow flag |
| err_divzero | output | 1 | Sticky divide-by-zero flag |

## Verification
Every result falls due a fixed number of cycles after its command is taken. An arithmetic result is in place at the edge that accepts the command. A push finishes 2 cycles later, or 3 when it must spill first. A pop finishes 1 cycle later, and a refill adds 2 more to a pop or an arithmetic command. The bench drives commands at the falling edge and counts the falling edges at which `cmd_ready` is low after acceptance. It compares that count against these figures, and it reads results only after `cmd_ready` has returned. Stack contents are observed through pops into the bench's memory model, and spill and fill addresses through the words found in the spill region.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    CMD_PUSH = 3'd0,
    CMD_POP  = 3'd1,
    CMD_ADD  = 3'd2,
    CMD_SUB  = 3'd3,
    CMD_MUL  = 3'd4,
    CMD_DIV  = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    CA_HOLD,
    CA_PUSH,
    CA_POP,
    CA_MERGE,
    CA_DROP,
    CA_FILL
  } cache_act_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPILL,
    ST_LDREQ,
    ST_LDCAP,
    ST_POPWR,
    ST_FLREQ,
    ST_FLCAP
  } state_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 32
) (
  input  stk_pkg::cmd_e  op,
  input  logic [W-1:0]   lhs,
  input  logic [W-1:0]   rhs,
  output logic [W-1:0]   res,
  output logic           div_zero
);
  import stk_pkg::*;

  always_comb begin
    res      = '0;
    div_zero = 1'b0;
    case (op)
      CMD_ADD: res = lhs + rhs;
      CMD_SUB: res = lhs - rhs;
      CMD_MUL: res = lhs * rhs;
      CMD_DIV: begin
        if (rhs == '0) begin
          div_zero = 1'b1;
        end else if (rhs == '1) begin
          // negation wraps for the most negative value
          res = '0 - lhs;
        end else begin
          res = $signed(lhs) / $signed(rhs);
        end
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_cache.sv
module stk_cache #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  stk_pkg::cache_act_e         act,
  input  logic [W-1:0]                din,
  output logic [DEPTH-1:0][W-1:0]     ent,
  output logic [CNT_W-1:0]            cnt
);
  import stk_pkg::*;

  // entry 0 is the top of the stack
  logic [DEPTH-1:0][W-1:0] sh_dn;
  logic [DEPTH-1:0][W-1:0] sh_up;

  assign sh_dn = {ent[DEPTH-2:0], din};
  assign sh_up = {{W{1'b0}}, ent[DEPTH-1:1]};

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] q;
    logic [W-1:0] nxt;

    always_comb begin
      case (act)
        CA_PUSH:  nxt = sh_dn[i];
        CA_POP:   nxt = sh_up[i];
        CA_MERGE: nxt = (i == 0) ? din : sh_up[i];
        CA_FILL:  nxt = (cnt == CNT_W'(i)) ? din : q;
        default:  nxt = q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end

    assign ent[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case (act)
        CA_PUSH, CA_FILL:          cnt <= cnt + CNT_W'(1);
        CA_POP, CA_MERGE, CA_DROP: cnt <= cnt - CNT_W'(1);
        default:                   cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/stk_spill_ptr.sv
module stk_spill_ptr #(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [ADDR_W-1:0] sp,
  output logic              at_base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= BASE;
    else if (inc) sp <= sp + ADDR_W'(1);
    else if (dec) sp <= sp - ADDR_W'(1);
  end

  assign at_base = (sp == BASE);
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit #(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 16,
  parameter int                DEPTH      = 4,
  parameter logic [ADDR_W-1:0] SPILL_BASE = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              err_underflow,
  output logic              err_divzero
);
  import stk_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  state_e                       state, st_n;
  cache_act_e                   act;
  logic [DATA_W-1:0]            din;
  logic [DEPTH-1:0][DATA_W-1:0] ent;
  logic [CNT_W-1:0]             cache_cnt;
  logic [ADDR_W-1:0]            spill_ptr;
  logic                         sp_at_base;
  logic                         sp_inc, sp_dec;
  logic [ADDR_W-1:0]            lat_addr;
  logic [DATA_W-1:0]            alu_res;
  logic                         alu_dz;
  logic                         set_uf, set_dz;
  logic                         accept;
  logic                         cache_full;
  logic                         refill_due;

  stk_cache #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_cache (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .din   (din),
    .ent   (ent),
    .cnt   (cache_cnt)
  );

  stk_spill_ptr #(.ADDR_W(ADDR_W), .BASE(SPILL_BASE)) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (sp_inc),
    .dec     (sp_dec),
    .sp      (spill_ptr),
    .at_base (sp_at_base)
  );

  stk_alu #(.W(DATA_W)) u_alu (
    .op       (cmd_e'(cmd_op)),
    .lhs      (ent[1]),
    .rhs      (ent[0]),
    .res      (alu_res),
    .div_zero (alu_dz)
  );

  assign cmd_ready  = (state == ST_IDLE);
  assign busy       = (state != ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign cache_full = (cache_cnt == CNT_W'(DEPTH));
  // two cached words, about to become one, with words still in memory
  assign refill_due = (cache_cnt == CNT_W'(2)) && !sp_at_base;

  always_comb begin
    st_n      = state;
    act       = CA_HOLD;
    din       = alu_res;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = lat_addr;
    mem_wdata = ent[0];
    set_uf    = 1'b0;
    set_dz    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          case (cmd_op)
            CMD_PUSH: st_n = cache_full ? ST_SPILL : ST_LDREQ;
            CMD_POP: begin
              if (cache_cnt == '0) set_uf = 1'b1;
              else                 st_n   = ST_POPWR;
            end
            CMD_ADD, CMD_SUB, CMD_MUL, CMD_DIV: begin
              if (cache_cnt < CNT_W'(2)) begin
                set_uf = 1'b1;
              end else begin
                act    = CA_MERGE;
                set_dz = alu_dz;
                if (refill_due) st_n = ST_FLREQ;
              end
            end
            default: st_n = ST_IDLE;
          endcase
        end
      end
      ST_SPILL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = spill_ptr;
        mem_wdata = ent[DEPTH-1];
        act       = CA_DROP;
        sp_inc    = 1'b1;
        st_n      = ST_LDREQ;
      end
      ST_LDREQ: begin
        mem_req = 1'b1;
        st_n    = ST_LDCAP;
      end
      ST_LDCAP: begin
        act  = CA_PUSH;
        din  = mem_rdata;
        st_n = ST_IDLE;
      end
      ST_POPWR: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        act     = CA_POP;
        st_n    = refill_due ? ST_FLREQ : ST_IDLE;
      end
      ST_FLREQ: begin
        mem_req  = 1'b1;
        mem_addr = spill_ptr - ADDR_W'(1);
        sp_dec   = 1'b1;
        st_n     = ST_FLCAP;
      end
      ST_FLCAP: begin
        act  = CA_FILL;
        din  = mem_rdata;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      lat_addr      <= '0;
      err_underflow <= 1'b0;
      err_divzero   <= 1'b0;
    end else begin
      state <= st_n;
      if (accept) lat_addr <= cmd_addr;
      if (set_uf) err_underflow <= 1'b1;
      if (set_dz) err_divzero   <= 1'b1;
    end
  end
endmodule

// File: rtl/stk_exec_unit_chk.sv
module stk_exec_unit_chk #(
  parameter int                ADDR_W = 16,
  parameter int                DEPTH  = 4,
  parameter int                CNT_W  = 3,
  parameter logic [ADDR_W-1:0] BASE   = 16'hFF00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              busy,
  input logic              err_underflow,
  input logic              err_divzero,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [CNT_W-1:0]  cnt,
  input logic [ADDR_W-1:0] sp
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_push_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd0) |=> busy);

  assert_divzero_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_divzero |=> err_divzero);

  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  assert_spill_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd0 && cnt == CNT_W'(DEPTH))
    |=> (mem_req && mem_we && mem_addr == sp));

  assert_cache_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_refilled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cnt >= CNT_W'(2) || sp == BASE));
endmodule

bind stk_exec_unit stk_exec_unit_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .BASE(SPILL_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_op        (cmd_op),
  .busy          (busy),
  .err_underflow (err_underflow),
  .err_divzero   (err_divzero),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .cnt           (cache_cnt),
  .sp            (spill_ptr)
);

// File: tb/stk_exec_unit_bench.sv
module stk_exec_unit_bench;
  localparam logic [15:0] BASE = 16'hFF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        busy, err_underflow, err_divzero;

  int n_chk = 0;
  int n_fail = 0;
  int n_wr = 0;
  logic [31:0] bmem [logic [15:0]];

  always #10 clk = ~clk;

  stk_exec_unit u_stk_exec_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .err_underflow(err_underflow), .err_divzero(err_divzero)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        bmem[mem_addr] = mem_wdata;
        n_wr = n_wr + 1;
      end else begin
        mem_rdata <= bmem.exists(mem_addr) ? bmem[mem_addr] : 32'hDEAD_BEEF;
      end
    end
  end

  // columns: a, b, c, d, e, expected (a-b)/(c-d*e), expected divzero flag
  localparam logic [31:0] VEC [5][7] = '{
    '{32'd20,       32'd8,        32'd10,       32'd2,        32'd3,        32'd3,        32'd0},
    '{32'hFFFFFFF9, 32'd2,        32'd1,        32'd1,        32'hFFFFFFFF, 32'hFFFFFFFC, 32'd0},
    '{32'd5,        32'hFFFFFFFD, 32'hFFFFFFFE, 32'd3,        32'hFFFFFFFF, 32'd8,        32'd0},
    '{32'd1000,     32'hFFFFFFE8, 32'd7,        32'hFFFFFFFB, 32'd1,        32'd85,       32'd0},
    '{32'd100,      32'd1,        32'd6,        32'd2,        32'd3,        32'd0,        32'd1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [15:0] addr, output int bcyc);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = addr;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    bcyc = 0;
    while (!cmd_ready) begin
      bcyc++;
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [15:0] addr);
    int dummy;
    do_cmd(op, addr, dummy);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int bc;
    logic [31:0] w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmd_ready && !busy && !err_underflow && !err_divzero && !mem_req, "R1 reset outputs",
          {27'd0, cmd_ready, busy, err_underflow, err_divzero, mem_req}, 32'h10);

    // vector table: f = (a-b)/(c-d*e), exercises R4 sub order, R5, R6
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 5; k++) bmem[16'h0010 + 16'(k)] = VEC[r][k];
      run(3'd0, 16'h0010); run(3'd0, 16'h0011); run(3'd3, 16'h0);
      run(3'd0, 16'h0012); run(3'd0, 16'h0013); run(3'd0, 16'h0014);
      run(3'd4, 16'h0);    run(3'd3, 16'h0);    run(3'd5, 16'h0);
      run(3'd1, 16'h0020);
      check(bmem[16'h0020] == VEC[r][5], "R4 R5 R6 table result", bmem[16'h0020], VEC[r][5]);
      check(err_divzero == VEC[r][6][0], "R6 table divzero flag", {31'd0, err_divzero}, VEC[r][6]);
      check(!err_underflow, "R7 no underflow on valid program", {31'd0, err_underflow}, 32'd0);
    end

    // R2 / R3 latency
    bmem[16'h0030] = 32'hA5A5_0001;
    do_cmd(3'd0, 16'h0030, bc);
    check(bc == 2, "R2 push busy cycles", bc, 2);
    do_cmd(3'd1, 16'h0040, bc);
    check(bc == 1, "R3 pop busy cycles", bc, 1);
    check(bmem[16'h0040] == 32'hA5A5_0001, "R3 pop value", bmem[16'h0040], 32'hA5A5_0001);

    // R8 spill
    for (int k = 0; k < 6; k++) bmem[16'h0050 + 16'(k)] = 32'd11 + 32'(k);
    bmem[BASE] = 32'd0;
    bmem[BASE + 16'd1] = 32'd0;
    for (int k = 0; k < 6; k++) begin
      do_cmd(3'd0, 16'h0050 + 16'(k), bc);
      if (k == 4) check(bc == 3, "R8 full push busy cycles", bc, 3);
    end
    check(bmem[BASE] == 32'd11, "R8 first spill word", bmem[BASE], 32'd11);
    check(bmem[BASE + 16'd1] == 32'd12, "R8 second spill word", bmem[BASE + 16'd1], 32'd12);

    // R9 fill and LIFO order
    for (int k = 0; k < 6; k++) begin
      do_cmd(3'd1, 16'h0060 + 16'(k), bc);
      if (k == 2) check(bc == 3, "R9 pop with refill busy cycles", bc, 3);
    end
    for (int k = 0; k < 6; k++)
      check(bmem[16'h0060 + 16'(k)] == 32'd16 - 32'(k), "R9 LIFO order across fills",
            bmem[16'h0060 + 16'(k)], 32'd16 - 32'(k));

    // R9 pointer shrank: next spill reuses base
    bmem[BASE] = 32'd0;
    for (int k = 0; k < 6; k++) run(3'd0, 16'h0050 + 16'(k));
    check(bmem[BASE] == 32'd11, "R9 spill reuses base after fills", bmem[BASE], 32'd11);
    for (int k = 0; k < 5; k++) begin
      do_cmd(3'd2, 16'h0, bc);
      if (k == 2) check(bc == 2, "R9 add with refill busy cycles", bc, 2);
      if (k == 0) check(bc == 0, "R4 add without refill busy cycles", bc, 0);
    end
    run(3'd1, 16'h0070);
    check(bmem[16'h0070] == 32'd81, "R4 add sum over spilled stack", bmem[16'h0070], 32'd81);

    // R4 subtract order and multiply
    bmem[16'h0031] = 32'd3; bmem[16'h0032] = 32'd10;
    run(3'd0, 16'h0031); run(3'd0, 16'h0032); run(3'd3, 16'h0); run(3'd1, 16'h0071);
    check(bmem[16'h0071] == 32'hFFFFFFF9, "R4 subtract second minus top", bmem[16'h0071], 32'hFFFFFFF9);
    bmem[16'h0033] = 32'h0001_0001;
    run(3'd0, 16'h0033); run(3'd0, 16'h0033); run(3'd4, 16'h0); run(3'd1, 16'h0072);
    check(bmem[16'h0072] == 32'h0002_0001, "R4 multiply low word", bmem[16'h0072], 32'h0002_0001);

    // R5 division corners
    bmem[16'h0034] = 32'h8000_0000; bmem[16'h0035] = 32'hFFFF_FFFF;
    run(3'd0, 16'h0034); run(3'd0, 16'h0035); run(3'd5, 16'h0); run(3'd1, 16'h0073);
    check(bmem[16'h0073] == 32'h8000_0000, "R5 min divided by minus one", bmem[16'h0073], 32'h8000_0000);
    bmem[16'h0036] = 32'd7; bmem[16'h0037] = 32'hFFFF_FFFE;
    run(3'd0, 16'h0036); run(3'd0, 16'h0037); run(3'd5, 16'h0); run(3'd1, 16'h0074);
    check(bmem[16'h0074] == 32'hFFFF_FFFD, "R5 truncation toward zero", bmem[16'h0074], 32'hFFFF_FFFD);

    // R11 reserved codes
    bmem[16'h0038] = 32'h1234_5678;
    run(3'd0, 16'h0038);
    w0 = 32'(n_wr);
    do_cmd(3'd7, 16'h0075, bc);
    check(bc == 0 && 32'(n_wr) == w0, "R11 reserved code no busy no write", bc, 0);
    do_cmd(3'd6, 16'h0075, bc);
    run(3'd1, 16'h0076);
    check(bmem[16'h0076] == 32'h1234_5678, "R11 stack unchanged by reserved codes", bmem[16'h0076], 32'h1234_5678);
    check(!err_underflow, "R11 flags unchanged", {31'd0, err_underflow}, 32'd0);

    // R7 underflow on empty and shallow stacks
    w0 = 32'(n_wr);
    run(3'd1, 16'h0080);
    check(err_underflow, "R7 pop on empty sets flag", {31'd0, err_underflow}, 32'd1);
    check(32'(n_wr) == w0, "R7 pop on empty writes nothing", 32'(n_wr), w0);
    bmem[16'h0039] = 32'h0BAD_CAFE;
    bmem[16'h0082] = 32'h5555_5555;
    run(3'd0, 16'h0039);
    run(3'd2, 16'h0);
    run(3'd1, 16'h0081);
    check(bmem[16'h0081] == 32'h0BAD_CAFE, "R7 shallow add leaves stack unchanged", bmem[16'h0081], 32'h0BAD_CAFE);
    w0 = 32'(n_wr);
    run(3'd1, 16'h0082);
    check(bmem[16'h0082] == 32'h5555_5555 && 32'(n_wr) == w0, "R7 stack was left with one word",
          bmem[16'h0082], 32'h5555_5555);

    // R10 back-pressure: pop held while push is busy
    bmem[16'h003A] = 32'hC0DE_0010;
    w0 = 32'(n_wr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_addr = 16'h003A;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_op = 3'd1; cmd_addr = 16'h0090;
    bc = 0;
    while (!cmd_ready) begin
      bc++;
      @(negedge clk);
    end
    check(bc == 2, "R10 held command waits for ready", bc, 2);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!cmd_ready) @(negedge clk);
    check(bmem[16'h0090] == 32'hC0DE_0010, "R10 held pop taken once ready", bmem[16'h0090], 32'hC0DE_0010);
    check(32'(n_wr) == w0 + 32'd1, "R10 held pop taken exactly once", 32'(n_wr), w0 + 32'd1);

    finish_run();
  end
endmodule